// File: doc/BRIEF.md
# Clock Output Run, Park and Tristate Control

This block decides, for each of eight clock output pairs, whether the pair toggles, is held in a driven parked state, or is released to high impedance. Its inputs are a per-output enable pin with programmable polarity, a per-output software enable, a per-output flag that marks the output as stoppable, one global active-low stop input, and a mode bit that picks how stopped outputs are parked. The output clock is modelled as the block clock `clk_i` gated per lane. The true side of each pair follows `clk_i` while the lane runs, and the complement side is its inverse.

The enable pins and the stop input are asynchronous. They pass through a two-flop synchroniser, and one decision register follows. The lane's gating register then updates on the falling edge of `clk_i`, so a change takes effect only while the clock is low and no shortened pulse can appear. A pin or stop change therefore reaches the outputs three output clock cycles after it is sampled. The software fields are synchronous to `clk_i` and skip the synchroniser.

Top module: `dif_run_ctrl`

## Requirements
- R1: While `rst_ni` is low, every lane has `drv_o`=0, `true_o`=0 and `comp_o`=0.
- R2: A lane runs when it is enabled and not stopped. During the high phase of `clk_i` it shows `true_o`=1, `comp_o`=0 and `drv_o`=1. During the low phase it shows `true_o`=0, `comp_o`=1 and `drv_o`=1.
- R3: A lane is disabled when its pin is inactive or its software enable bit `sw_en_i[n]` is 0. A disabled lane is high impedance, with `drv_o`=0, `true_o`=0 and `comp_o`=0, whatever the stop input is.
- R4: The pin polarity is set by `oe_pol_i`. When `oe_pol_i`=1, a pin at 1 is active. When `oe_pol_i`=0, a pin at 0 is active.
- R5: `stop_ni`=0 stops only the enabled lanes whose `stop_en_i[n]` is 1. Lanes whose `stop_en_i[n]` is 0 keep running.
- R6: A stopped lane is parked in one of two ways. With `park_hiz_i`=0 it is parked driven, with `true_o`=0, `comp_o`=1 and `drv_o`=1 in both clock phases. With `park_hiz_i`=1 it is high impedance, with all three outputs at 0.
- R7: Timing of input changes. Pin and `stop_ni` values sampled at rising edge t govern the high phase that starts at rising edge t+3. Values of `sw_en_i`, `stop_en_i`, `oe_pol_i` and `park_hiz_i` sampled at rising edge t govern the high phase that starts at rising edge t+1.
- R8: A lane's mode changes only at a falling edge of `clk_i`. `true_o` is never high while `clk_i` is low, and every pulse on `true_o` spans a full high phase.
- R9: On every driven lane, `comp_o` is the inverse of `true_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source output clock; also clocks the control logic |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_pin_i | input | 8 | Per-lane enable pins, asynchronous |
| stop_ni | input | 1 | Global stop, active low, asynchronous |
| oe_pol_i | input | 1 | Pin polarity: 1 means active high, 0 means active low |
| sw_en_i | input | 8 | Per-lane software enable (1 = enabled) |
| stop_en_i | input | 8 | Per-lane stop flag (1 = stoppable, 0 = free-running) |
| park_hiz_i | input | 1 | Park mode for stopped lanes: 0 = driven, 1 = high impedance |
| true_o | output | 8 | True side of each clock pair |
| comp_o | output | 8 | Complement side of each clock pair |
| drv_o | output | 8 | Per-lane driver enable (0 = high impedance) |

## Verification
The assertions assume that `rst_ni` is released away from a rising edge of `clk_i`. They also assume that the software fields change only while `clk_i` is low, so that the negative-edge gating register never sees a decision change in the same half cycle. The bench changes every input only at falling edges of `clk_i`, with the asynchronous pins included. It holds most inputs for several cycles and flips single bits with low probability, so that running, parked-driven and high-impedance states each persist long enough to be observed.

// File: rtl/dif_pkg.sv
package dif_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ = 2'd0,
    MODE_DRV = 2'd1,
    MODE_RUN = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/dif_sync.sv
module dif_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dif_decide.sv
module dif_decide #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_s_i,
  input  logic         stop_ns_i,
  input  logic         oe_pol_i,
  input  logic [N-1:0] sw_en_i,
  input  logic [N-1:0] stop_en_i,
  input  logic         park_hiz_i,
  output logic [N-1:0] run_o,
  output logic [N-1:0] drv_o
);
  import dif_pkg::*;

  logic [N-1:0] run_d, drv_d;

  for (genvar n = 0; n < N; n++) begin : g_lane
    lane_mode_e md;
    always_comb begin
      if (!((pin_s_i[n] == oe_pol_i) && sw_en_i[n]))
        md = MODE_HIZ;
      else if (stop_en_i[n] && !stop_ns_i)
        md = park_hiz_i ? MODE_HIZ : MODE_DRV;
      else
        md = MODE_RUN;
    end
    assign run_d[n] = (md == MODE_RUN);
    assign drv_d[n] = (md != MODE_HIZ);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= '0;
      drv_o <= '0;
    end else begin
      run_o <= run_d;
      drv_o <= drv_d;
    end
  end
endmodule

// File: rtl/dif_gate.sv
module dif_gate #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] run_i,
  input  logic [N-1:0] drv_i,
  output logic [N-1:0] true_o,
  output logic [N-1:0] comp_o,
  output logic [N-1:0] drv_o
);
  logic [N-1:0] run_q, drv_q;

  // update while clock is low: no runt pulse on the gated clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      drv_q <= '0;
    end else begin
      run_q <= run_i;
      drv_q <= drv_i;
    end
  end

  assign true_o = {N{clk_i}} & run_q;
  assign comp_o = drv_q & ~true_o;
  assign drv_o  = drv_q;
endmodule

// File: rtl/dif_run_ctrl.sv
module dif_run_ctrl #(
  parameter int unsigned N           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] oe_pin_i,
  input  logic         stop_ni,
  input  logic         oe_pol_i,
  input  logic [N-1:0] sw_en_i,
  input  logic [N-1:0] stop_en_i,
  input  logic         park_hiz_i,
  output logic [N-1:0] true_o,
  output logic [N-1:0] comp_o,
  output logic [N-1:0] drv_o
);
  localparam int unsigned SW = N + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {N{1'b0}}};

  logic [SW-1:0] async_in, sync_out;
  logic [N-1:0]  run_dec, drv_dec;

  assign async_in = {stop_ni, oe_pin_i};

  dif_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_in),
    .q_o   (sync_out)
  );

  dif_decide #(.N(N)) u_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_s_i   (sync_out[N-1:0]),
    .stop_ns_i (sync_out[N]),
    .oe_pol_i  (oe_pol_i),
    .sw_en_i   (sw_en_i),
    .stop_en_i (stop_en_i),
    .park_hiz_i(park_hiz_i),
    .run_o     (run_dec),
    .drv_o     (drv_dec)
  );

  dif_gate #(.N(N)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_dec),
    .drv_i (drv_dec),
    .true_o(true_o),
    .comp_o(comp_o),
    .drv_o (drv_o)
  );
endmodule

// File: rtl/dif_run_ctrl_chk.sv
module dif_run_ctrl_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] true_o,
  input logic [N-1:0] comp_o,
  input logic [N-1:0] drv_o
);
  // R1: quiet during reset
  assert_rst_quiet_R1: assert property (@(negedge clk_i)
    !rst_ni |-> (drv_o == '0 && true_o == '0 && comp_o == '0));

  // R8: sampled just before a rising edge the clock is low, so no lane may be high
  assert_true_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    true_o == '0);

  // R3: an undriven lane shows nothing, in either phase
  assert_hiz_quiet_hi_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (~drv_o & (true_o | comp_o)) == '0);
  assert_hiz_quiet_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~drv_o & (true_o | comp_o)) == '0);

  // R9: driven lanes keep the pair complementary
  assert_pair_opposite_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (drv_o & ~(true_o ^ comp_o)) == '0);
endmodule

bind dif_run_ctrl dif_run_ctrl_chk #(.N(N)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .true_o(true_o),
  .comp_o(comp_o),
  .drv_o (drv_o)
);

// File: tb/tb_dif_run_ctrl.sv
module tb_dif_run_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni;
  logic [N-1:0] oe_pin, sw_en, stop_en;
  logic stop_n, oe_pol, park_hiz;
  logic [N-1:0] true_o, comp_o, drv_o;

  int total = 0;
  int bad = 0;
  string ctx = "reset";

  always #5 clk = ~clk;

  dif_run_ctrl #(.N(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .oe_pin_i(oe_pin), .stop_ni(stop_n),
    .oe_pol_i(oe_pol), .sw_en_i(sw_en), .stop_en_i(stop_en),
    .park_hiz_i(park_hiz), .true_o(true_o), .comp_o(comp_o), .drv_o(drv_o)
  );

  // 0 = hiz, 1 = parked driven, 2 = run
  function automatic int exp_mode(input logic [N:0] p, input logic [2*N+1:0] r, input int n);
    logic pol, phz;
    logic [N-1:0] sw, sen;
    {pol, phz, sw, sen} = r;
    if (!((p[n] == pol) && sw[n])) return 0;
    if (sen[n] && !p[N]) return phz ? 0 : 1;
    return 2;
  endfunction

  function automatic string mode_tag(input int m, input logic [N:0] p, input logic [2*N+1:0] r, input int n);
    if (m == 2) return "R2/R9";
    if (m == 1) return "R6";
    if ((p[n] == r[2*N+1]) && r[N+n]) return "R6";
    return "R3";
  endfunction

  task automatic chk(input string tag, input int n, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s [%s] lane %0d: true/comp/drv got %b exp %b", tag, ctx, n, got, exp);
    end
  endtask

  // monitor with input history (R7 latencies)
  logic [N:0]       ph1, ph2, ph3, ph4;
  logic [2*N+1:0]   rh1, rh2;
  int since = 0;

  always begin
    @(posedge clk);
    ph4 = ph3; ph3 = ph2; ph2 = ph1; ph1 = {stop_n, oe_pin};
    rh2 = rh1; rh1 = {oe_pol, park_hiz, sw_en, stop_en};
    if (!rst_ni) since = 0; else since++;
    #2;
    if (!rst_ni) begin
      for (int n = 0; n < N; n++) chk("R1", n, {true_o[n], comp_o[n], drv_o[n]}, 3'b000);
    end else if (since >= 4) begin
      for (int n = 0; n < N; n++) begin
        int m;
        logic [2:0] e;
        m = exp_mode(ph4, rh2, n);
        e = (m == 2) ? 3'b101 : (m == 1) ? 3'b011 : 3'b000;
        chk(mode_tag(m, ph4, rh2, n), n, {true_o[n], comp_o[n], drv_o[n]}, e);
      end
    end
    @(negedge clk);
    #2;
    if (rst_ni && since >= 4) begin
      for (int n = 0; n < N; n++) begin
        int m;
        m = exp_mode(ph3, rh1, n);
        chk("R8 low phase", n, {true_o[n], comp_o[n], drv_o[n]}, (m == 0) ? 3'b000 : 3'b011);
      end
    end
  end

  task automatic apply(input string c, input logic [N-1:0] p, input logic sn, input logic pl,
                       input logic [N-1:0] sw, input logic [N-1:0] se, input logic phz, input int cyc);
    @(negedge clk);
    ctx = c; oe_pin = p; stop_n = sn; oe_pol = pl; sw_en = sw; stop_en = se; park_hiz = phz;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    rst_ni = 1'b0; oe_pin = '1; stop_n = 1'b1; oe_pol = 1'b1;
    sw_en = '1; stop_en = '0; park_hiz = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    apply("R2 all running",          8'hFF, 1, 1, 8'hFF, 8'h00, 0, 10);
    apply("R3 software disable",     8'hFF, 1, 1, 8'h0F, 8'h00, 0, 10);
    apply("R3 pin disable",          8'hA5, 1, 1, 8'hFF, 8'h00, 0, 10);
    apply("R4 active-low pins",      8'h33, 1, 0, 8'hFF, 8'h00, 0, 10);
    apply("R5 stop driven park",     8'hFF, 0, 1, 8'hFF, 8'hF0, 0, 10);
    apply("R6 stop hiz park",        8'hFF, 0, 1, 8'hFF, 8'hF0, 1, 10);
    apply("R5 stop on disabled lane", 8'h0F, 0, 1, 8'hFF, 8'hFF, 0, 10);
    apply("R7 pin edge latency",     8'h00, 1, 1, 8'hFF, 8'h00, 0, 6);
    apply("R7 pin edge latency",     8'h01, 1, 1, 8'hFF, 8'h00, 0, 6);
    apply("R7 register latency",     8'h01, 1, 1, 8'h00, 8'h00, 0, 1);
    apply("R7 register latency",     8'h01, 1, 1, 8'hFF, 8'h00, 0, 6);
    ctx = "random";
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ($urandom % 4 == 0)  oe_pin[$urandom % N] ^= 1'b1;
      if ($urandom % 8 == 0)  stop_n = ~stop_n;
      if ($urandom % 64 == 0) oe_pol = ~oe_pol;
      if ($urandom % 16 == 0) sw_en[$urandom % N] ^= 1'b1;
      if ($urandom % 16 == 0) stop_en[$urandom % N] ^= 1'b1;
      if ($urandom % 32 == 0) park_hiz = ~park_hiz;
    end
    ctx = "R1 reset again";
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, got no end exp end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule